// File: doc/BRIEF.md
# Slotted Broadcast Bus with Collision Detection

This block links a small fixed set of identical processing components through a shared, word-wide broadcast medium. Time is divided into slots of one clock cycle each. In any slot, a component that raises its send-enable places a word on its sub-bus, and every component attached to that sub-bus receives the word in the following cycle. The medium has no arbitration and no handshake. Which component sends in which slot is fixed in advance by the program the components run, so the block only carries values and checks that this schedule was respected.

The wires can be split into several independent sub-buses. A static per-component group select attaches each component to one sub-bus. This lets several separate values, such as guard results, travel in the same slot. If two or more components drive the same sub-bus in one slot, that sub-bus delivers nothing, and a sticky error flag and a mask of the offending drivers are raised until software-independent control logic pulses the clear input.

Top module: `bcast_bus`

## Requirements
- R1: When exactly one component on a sub-bus sends in a slot, every component attached to that sub-bus (the sender included) sees that word on its receive port with its receive-valid high in the next cycle.
- R2: When no component on a sub-bus sends, every component on it sees receive data of zero and receive-valid low in the next cycle.
- R3: Component c belongs to sub-bus number grpSel[c*GRP_W +: GRP_W]; sub-buses carry their own single-sender broadcasts in the same slot without affecting each other.
- R4: When two or more components on one sub-bus send in the same slot, that sub-bus delivers zero with receive-valid low in the next cycle, and collErr goes high in that cycle.
- R5: collMask bit c is set in the cycle after component c sent on a sub-bus that had a collision. Bits accumulate over later collisions, and components that did not drive a colliding sub-bus keep their bit clear.
- R6: collErr and collMask hold their values over later slots until errClear is sampled high. A clear in a slot with no collision leaves both at zero. A clear in a slot with a new collision leaves exactly the new slot's mask.
- R7: A collision on one sub-bus does not disturb a single-sender broadcast on another sub-bus in the same slot.
- R8: After reset, all receive data, receive-valid bits, collErr and collMask are zero.
- R9: The data input of a component whose send-enable is low has no effect on any receive port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sendEn | input | NUM_COMP | Per-component drive request for this slot |
| sendData | input | NUM_COMP*DATA_W | Per-component word; component c at [c*DATA_W +: DATA_W] |
| grpSel | input | NUM_COMP*GRP_W | Static sub-bus select; component c at [c*GRP_W +: GRP_W] |
| errClear | input | 1 | Clears the sticky collision state |
| rxData | output | NUM_COMP*DATA_W | Word seen by each component, one cycle after the slot |
| rxValid | output | NUM_COMP | High when the component's sub-bus had exactly one sender |
| collErr | output | 1 | Sticky multiple-sender error |
| collMask | output | NUM_COMP | Sticky mask of components that drove a colliding sub-bus |

## Verification
The assertions check on every cycle that a collision always raises the error one cycle later, and that the error stays up with no clear. They also check that a clear with no new collision drops it, that an invalid receive port reads zero, and that a sender which sees valid data reads back its own word. The bench scenarios are needed to show how values are routed across sub-buses. They also show that the mask accumulates and that clear and collision interact correctly in one slot. Finally, they show that a colliding sub-bus does not disturb a clean one, and that disabled senders' data has no effect.

// File: rtl/bcast_pkg.sv
package bcast_pkg;
  parameter int MAX_GRP = 8;

  // Per-sub-bus strobes from the control to the datapath
  typedef struct packed {
    logic [MAX_GRP-1:0] active;   // at least one sender
    logic [MAX_GRP-1:0] collide;  // two or more senders
  } busStrobe_t;
endpackage

// File: rtl/bcast_ctrl.sv
module bcast_ctrl
  import bcast_pkg::*;
#(
  parameter int NUM_COMP = 6,
  parameter int NUM_GRP  = 2,
  parameter int GRP_W    = 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_COMP-1:0]       sendEn,
  input  logic [NUM_COMP*GRP_W-1:0] grpSel,
  input  logic                      errClear,
  output busStrobe_t                strobe,
  output logic                      collErr,
  output logic [NUM_COMP-1:0]       collMask
);
  logic [NUM_COMP-1:0] member [NUM_GRP];
  logic [NUM_COMP-1:0] newMask;

  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      for (int c = 0; c < NUM_COMP; c++) begin
        member[g][c] = sendEn[c] && (int'(grpSel[c*GRP_W +: GRP_W]) == g);
      end
    end
  end

  always_comb begin
    strobe = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      strobe.active[g]  = |member[g];
      strobe.collide[g] = |(member[g] & (member[g] - 1'b1));
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_COMP; c++) begin
      newMask[c] = sendEn[c] && strobe.collide[grpSel[c*GRP_W +: GRP_W]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      collErr  <= 1'b0;
      collMask <= '0;
    end else if (errClear) begin
      collErr  <= |newMask;
      collMask <= newMask;
    end else begin
      collErr  <= collErr | (|newMask);
      collMask <= collMask | newMask;
    end
  end

  // R4: any multi-driven sub-bus raises the flag next cycle
  p_coll_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|newMask) |=> collErr);
  // R6: sticky without a clear
  p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (collErr && !errClear) |=> collErr);
  // R6: clear with no new collision drops the flag
  p_err_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (errClear && (newMask == '0)) |=> (!collErr && collMask == '0));
endmodule

// File: rtl/bcast_datapath.sv
module bcast_datapath
  import bcast_pkg::*;
#(
  parameter int NUM_COMP = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_GRP  = 2,
  parameter int GRP_W    = 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_COMP-1:0]        sendEn,
  input  logic [NUM_COMP*DATA_W-1:0] sendData,
  input  logic [NUM_COMP*GRP_W-1:0]  grpSel,
  input  busStrobe_t                 strobe,
  output logic [NUM_COMP*DATA_W-1:0] rxData,
  output logic [NUM_COMP-1:0]        rxValid
);
  logic [DATA_W-1:0] grpWord [NUM_GRP];
  logic [NUM_GRP-1:0] grpClean;

  // Wired-OR of gated drivers per sub-bus
  always_comb begin
    for (int g = 0; g < NUM_GRP; g++) begin
      grpWord[g] = '0;
      for (int c = 0; c < NUM_COMP; c++) begin
        if (sendEn[c] && int'(grpSel[c*GRP_W +: GRP_W]) == g)
          grpWord[g] = grpWord[g] | sendData[c*DATA_W +: DATA_W];
      end
      grpClean[g] = strobe.active[g] && !strobe.collide[g];
    end
  end

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_rx
    logic [GRP_W-1:0] mySel;
    assign mySel = grpSel[c*GRP_W +: GRP_W];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rxData[c*DATA_W +: DATA_W] <= '0;
        rxValid[c]                 <= 1'b0;
      end else begin
        rxValid[c]                 <= grpClean[mySel];
        rxData[c*DATA_W +: DATA_W] <= grpClean[mySel] ? grpWord[mySel] : '0;
      end
    end
  end
endmodule

// File: rtl/bcast_bus.sv
module bcast_bus
  import bcast_pkg::*;
#(
  parameter int NUM_COMP = 6,
  parameter int DATA_W   = 16,
  parameter int NUM_GRP  = 2,
  parameter int GRP_W    = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_COMP-1:0]        sendEn,
  input  logic [NUM_COMP*DATA_W-1:0] sendData,
  input  logic [NUM_COMP*GRP_W-1:0]  grpSel,
  input  logic                       errClear,
  output logic [NUM_COMP*DATA_W-1:0] rxData,
  output logic [NUM_COMP-1:0]        rxValid,
  output logic                       collErr,
  output logic [NUM_COMP-1:0]        collMask
);
  busStrobe_t strobe;

  initial begin
    if (NUM_GRP > MAX_GRP) $error("NUM_GRP exceeds MAX_GRP");
  end

  bcast_ctrl #(.NUM_COMP(NUM_COMP), .NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sendEn(sendEn), .grpSel(grpSel),
    .errClear(errClear), .strobe(strobe), .collErr(collErr), .collMask(collMask)
  );

  bcast_datapath #(.NUM_COMP(NUM_COMP), .DATA_W(DATA_W), .NUM_GRP(NUM_GRP),
                   .GRP_W(GRP_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .sendEn(sendEn), .sendData(sendData),
    .grpSel(grpSel), .strobe(strobe), .rxData(rxData), .rxValid(rxValid)
  );

  for (genvar c = 0; c < NUM_COMP; c++) begin : g_chk
    // R2: a port without valid data reads zero
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !rxValid[c] |-> (rxData[c*DATA_W +: DATA_W] == '0));
    // R1: a sender that receives valid data reads back its own word
    p_echo_own_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sendEn[c]) && rxValid[c]) |->
        (rxData[c*DATA_W +: DATA_W] == $past(sendData[c*DATA_W +: DATA_W])));
  end
endmodule

// File: tb/sim_bcast_bus.sv
module sim_bcast_bus;
  localparam int NC = 6;
  localparam int DW = 16;
  localparam int NG = 2;
  localparam int GW = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NC-1:0] sendEn = '0;
  logic [NC*DW-1:0] sendData = '0;
  logic [NC*GW-1:0] grpSel = '0;
  logic errClear = 1'b0;
  logic [NC*DW-1:0] rxData;
  logic [NC-1:0] rxValid;
  logic collErr;
  logic [NC-1:0] collMask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bcast_bus #(.NUM_COMP(NC), .DATA_W(DW), .NUM_GRP(NG)) u0 (
    .clk(clk), .rst_n(rst_n), .sendEn(sendEn), .sendData(sendData),
    .grpSel(grpSel), .errClear(errClear), .rxData(rxData), .rxValid(rxValid),
    .collErr(collErr), .collMask(collMask)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Check every component attached to sub-bus g
  task automatic chkGroup(input string req, input int g, input logic [DW-1:0] d, input logic v);
    for (int c = 0; c < NC; c++) begin
      if (int'(grpSel[c*GW +: GW]) == g) begin
        chk(req, 32'(rxData[c*DW +: DW]), 32'(d));
        chk(req, 32'(rxValid[c]), 32'(v));
      end
    end
  endtask

  task automatic setWord(input int c, input logic [DW-1:0] d);
    sendData[c*DW +: DW] = d;
  endtask

  // Drive at negedge, hold one slot, sample at following negedge
  task automatic slot(input logic [NC-1:0] en, input logic clr);
    sendEn = en;
    errClear = clr;
    @(negedge clk);
    sendEn = '0;
    errClear = 1'b0;
  endtask

  task automatic tReset;
    chk("R8 data", 32'(rxData == '0), 32'd1);
    chk("R8 valid", 32'(rxValid), 32'd0);
    chk("R8 err", 32'(collErr), 32'd0);
    chk("R8 mask", 32'(collMask), 32'd0);
  endtask

  task automatic tIdle;
    grpSel = '0;
    for (int c = 0; c < NC; c++) setWord(c, 16'h1111 * (c + 1));
    slot('0, 1'b0);
    chkGroup("R2 idle", 0, '0, 1'b0);
    chk("R2 no err", 32'(collErr), 32'd0);
  endtask

  task automatic tSingle;
    grpSel = '0;
    setWord(1, 16'hA5A5);
    slot(6'b000010, 1'b0);
    chkGroup("R1 single", 0, 16'hA5A5, 1'b1);
  endtask

  task automatic tSplit;
    grpSel = 6'b111000;
    setWord(0, 16'h1234);
    setWord(4, 16'hBEEF);
    slot(6'b010001, 1'b0);
    chkGroup("R3 grp0", 0, 16'h1234, 1'b1);
    chkGroup("R3 grp1", 1, 16'hBEEF, 1'b1);
  endtask

  task automatic tIgnore;
    grpSel = 6'b111000;
    for (int c = 0; c < NC; c++) setWord(c, 16'hFFFF);
    setWord(3, 16'h00F0);
    slot(6'b001000, 1'b0);
    chkGroup("R9 grp1", 1, 16'h00F0, 1'b1);
    chkGroup("R9 grp0", 0, 16'h0000, 1'b0);
  endtask

  task automatic tCollide;
    grpSel = 6'b111000;
    setWord(0, 16'h0F0F);
    setWord(2, 16'hF000);
    setWord(5, 16'h5555);
    slot(6'b100101, 1'b0);
    chkGroup("R4 grp0", 0, '0, 1'b0);
    chk("R4 err", 32'(collErr), 32'd1);
    chkGroup("R7 grp1", 1, 16'h5555, 1'b1);
    chk("R5 mask", 32'(collMask), 32'b000101);
  endtask

  task automatic tSticky;
    grpSel = 6'b111000;
    slot('0, 1'b0);
    chk("R6 hold err", 32'(collErr), 32'd1);
    chk("R6 hold mask", 32'(collMask), 32'b000101);
    setWord(3, 16'h0001);
    setWord(4, 16'h0002);
    slot(6'b011000, 1'b0);
    chk("R5 accum", 32'(collMask), 32'b011101);
    chkGroup("R4 grp1", 1, '0, 1'b0);
    slot('0, 1'b1);
    chk("R6 clear err", 32'(collErr), 32'd0);
    chk("R6 clear mask", 32'(collMask), 32'd0);
    slot(6'b000110, 1'b1);
    chk("R6 clr+coll err", 32'(collErr), 32'd1);
    chk("R6 clr+coll mask", 32'(collMask), 32'b000110);
    slot('0, 1'b1);
    chk("R6 final clear", 32'(collErr), 32'd0);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    tReset();
    tIdle();
    tSingle();
    tSplit();
    tIgnore();
    tCollide();
    tSticky();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule